// File: doc/BRIEF.md
# DMA Transfer Control Sequencer

This block is the control engine behind one arbitration pass of a DMA channel. On a start strobe it fetches the channel's three-word descriptor from a table in system memory. It then moves a burst of data words from the source region to the destination region and writes the updated control word back to the table. When the whole transfer is exhausted it raises a one-cycle done pulse. All memory traffic goes through a single master port that carries one access at a time. The port holds a request until the memory answers with an acknowledge or an error. Throughout, the engine reports its current state as a 4-bit code.

The descriptor for channel `n` starts at `descBase + 16*n`. Its words are the source end pointer at +0, the destination end pointer at +4 and the control word at +8. The control word carries these fields:

- the remaining item count minus one;
- an exponent R, so that one pass moves up to 2^R items;
- the protection bits used for the source data reads;
- the protection bits used for the destination data writes.

Data item addresses are counted backwards from the end pointers, so the last item of the whole transfer sits exactly at the end pointer. Descriptor accesses carry a separate, globally configured protection value. A global enable can freeze the engine between accesses. A per-pass option makes the engine hold until the peripheral request drops. A bus error aborts the pass and sets a sticky flag.

Top module: `dma_seq`

## Requirements
- R1: After reset `seqState` is 0 (idle), `memReq` is 0, `done` is 0 and `busErr` is 0.
- R2: While `masterEn` is 0 in the idle state, a `start` pulse is ignored: the state stays 0 and no memory access is made.
- R3: After `start` with `masterEn` 1, the engine makes three descriptor reads (`memWe` 0) in this fixed order. The first is the control word at `descBase+16*n+8` with state code 1. The second is the source end pointer at `+0` with state 2. The third is the destination end pointer at `+4` with state 3. Here `n` is `chanSel` sampled at start. An access completes in the cycle in which `memAck` or `memErr` is 1 while `memReq` is 1.
- R4: The control word holds the count minus one `c` in bits [19:10] and the exponent R in bits [9:6]. The engine moves `m = min(2^R, c+1)` items. For item k = 0..m-1 it first reads at `srcEnd - 4*(c-k)` with state 4. It then writes the data just read to `dstEnd - 4*(c-k)` with `memWe` 1 and state 5.
- R5: Descriptor reads and the write-back carry `memProt = cfgProt`, where bit 2 means cacheable, bit 1 bufferable and bit 0 privileged. Source data reads carry control-word bits [5:3]. Destination data writes carry control-word bits [2:0].
- R6: After the data phase the engine writes the control word back to `descBase+16*n+8` with state 7. The written word has the count field set to `c-m`, or to 0 when `m = c+1`, and all other bits unchanged.
- R7: When `m = c+1`, the write-back is followed by exactly one cycle with `done` 1 and state 9, then state 0. When `m < c+1`, the engine returns to state 0 with no done pulse.
- R8: If `waitOnReq` and `chanReq` are both 1 when the last data write completes, the engine enters state 6. It makes no access while `chanReq` stays 1, and goes on to the write-back once `chanReq` is 0.
- R9: If `masterEn` is 0 when an access completes and the next step is another access or the request wait, the engine enters state 8 with no access. It resumes that next step, with the same sequence of accesses, once `masterEn` returns to 1.
- R10: An access answered with `memErr` sets `busErr`. The engine then returns to state 0 with no further access, including no write-back. `busErr` stays 1 until `errClear` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterEn | input | 1 | Global engine enable |
| start | input | 1 | Begin one arbitration pass for `chanSel` |
| chanSel | input | CH_W | Channel number, sampled at start |
| descBase | input | ADDR_W | Base address of the descriptor table |
| cfgProt | input | 3 | Protection bits for descriptor accesses |
| waitOnReq | input | 1 | Hold before write-back until the request drops |
| chanReq | input | 1 | Peripheral request level of the active channel |
| errClear | input | 1 | Clears the sticky bus-error flag |
| memReq | output | 1 | Memory access request, held until answered |
| memWe | output | 1 | 1 for a write access |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | DATA_W | Write data |
| memProt | output | 3 | Protection bits of the access |
| memAck | input | 1 | Access completed normally |
| memErr | input | 1 | Access completed with a bus error |
| memRdata | input | DATA_W | Read data, valid with `memAck` |
| seqState | output | 4 | Current state code |
| done | output | 1 | One-cycle pulse when a transfer is exhausted |
| busErr | output | 1 | Sticky bus-error flag |

## Verification
The bench predicts every memory access from the descriptor contents: address, direction, protection, state code and write data. It compares each access as the design presents it. It runs one channel through three passes so that the partial-burst arithmetic is chained through the written-back word: a design that mis-subtracts would drift addresses or miss the final done. It also covers a single-item pass with R of 0 and a burst exactly equal to the remaining count. A wrong last-item decision would add or drop a data pair or pulse done early. Further cases drop the enable mid-pass, hold the request during the wait state, and inject an error on the third descriptor read. A design that leaked an access while stalled or waiting, lost its place on resume, or wrote back after an error would show an unexpected or missing access.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_RD_CTRL  = 4'd1,
    ST_RD_SRCP  = 4'd2,
    ST_RD_DSTP  = 4'd3,
    ST_RD_DATA  = 4'd4,
    ST_WR_DATA  = 4'd5,
    ST_WAIT_REQ = 4'd6,
    ST_WR_CTRL  = 4'd7,
    ST_STALL    = 4'd8,
    ST_DONE     = 4'd9,
    ST_SG_XFER  = 4'd10
  } seqState_e;

  typedef enum logic [2:0] {
    AS_CTRL = 3'd0,
    AS_SRCP = 3'd1,
    AS_DSTP = 3'd2,
    AS_SRCD = 3'd3,
    AS_DSTD = 3'd4
  } addrSel_e;

  typedef struct packed {
    logic     ldChan;
    logic     ldCtrl;
    logic     ldSrc;
    logic     ldDst;
    logic     ldData;
    logic     clrIdx;
    logic     incIdx;
    addrSel_e addrSel;
  } dpStrobe_t;

  function automatic logic isWorkState(seqState_e st);
    return (st >= ST_RD_CTRL) && (st <= ST_WR_CTRL);
  endfunction

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      masterEn,
  input  logic      start,
  input  logic      waitOnReq,
  input  logic      chanReq,
  input  logic      errClear,
  input  logic      memAck,
  input  logic      memErr,
  input  logic      lastItem,
  input  logic      exhaust,
  output seqState_e state,
  output dpStrobe_t strb,
  output logic      memReq,
  output logic      memWe,
  output logic      done,
  output logic      busErr
);

  seqState_e nextSt;
  seqState_e cand;
  seqState_e resumeSt;
  logic      adv;
  logic      beatOk;

  always_comb begin
    nextSt       = state;
    cand         = state;
    adv          = 1'b0;
    strb         = '0;
    strb.addrSel = AS_CTRL;
    memReq       = 1'b0;
    memWe        = 1'b0;
    beatOk       = memAck && !memErr;
    case (state)
      ST_IDLE: begin
        if (start && masterEn) begin
          strb.ldChan = 1'b1;
          nextSt      = ST_RD_CTRL;
        end
      end
      ST_RD_CTRL: begin
        memReq       = 1'b1;
        strb.addrSel = AS_CTRL;
        if (beatOk) begin
          strb.ldCtrl = 1'b1;
          cand        = ST_RD_SRCP;
          adv         = 1'b1;
        end
      end
      ST_RD_SRCP: begin
        memReq       = 1'b1;
        strb.addrSel = AS_SRCP;
        if (beatOk) begin
          strb.ldSrc = 1'b1;
          cand       = ST_RD_DSTP;
          adv        = 1'b1;
        end
      end
      ST_RD_DSTP: begin
        memReq       = 1'b1;
        strb.addrSel = AS_DSTP;
        if (beatOk) begin
          strb.ldDst  = 1'b1;
          strb.clrIdx = 1'b1;
          cand        = ST_RD_DATA;
          adv         = 1'b1;
        end
      end
      ST_RD_DATA: begin
        memReq       = 1'b1;
        strb.addrSel = AS_SRCD;
        if (beatOk) begin
          strb.ldData = 1'b1;
          cand        = ST_WR_DATA;
          adv         = 1'b1;
        end
      end
      ST_WR_DATA: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.addrSel = AS_DSTD;
        if (beatOk) begin
          strb.incIdx = 1'b1;
          adv         = 1'b1;
          if (!lastItem)                  cand = ST_RD_DATA;
          else if (waitOnReq && chanReq)  cand = ST_WAIT_REQ;
          else                            cand = ST_WR_CTRL;
        end
      end
      ST_WAIT_REQ: begin
        if (!chanReq) begin
          cand = ST_WR_CTRL;
          adv  = 1'b1;
        end
      end
      ST_WR_CTRL: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.addrSel = AS_CTRL;
        if (beatOk) begin
          cand = exhaust ? ST_DONE : ST_IDLE;
          adv  = 1'b1;
        end
      end
      ST_STALL: begin
        if (masterEn) nextSt = resumeSt;
      end
      ST_DONE:  nextSt = ST_IDLE;
      default:  nextSt = ST_IDLE;
    endcase
    if (adv) nextSt = (!masterEn && isWorkState(cand)) ? ST_STALL : cand;
    if (memReq && memErr) nextSt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      resumeSt <= ST_IDLE;
      busErr   <= 1'b0;
    end else begin
      state <= nextSt;
      if (adv && !masterEn) resumeSt <= cand;
      if (memReq && memErr) busErr <= 1'b1;
      else if (errClear)    busErr <= 1'b0;
    end
  end

  assign done = (state == ST_DONE);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !masterEn) |=> state == ST_IDLE);

  a_r3_fetch_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_CTRL && memAck && !memErr && masterEn) |=> state == ST_RD_SRCP);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && state == ST_IDLE));

  a_r8_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_REQ && chanReq) |=> state == ST_WAIT_REQ);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STALL && !masterEn) |=> state == ST_STALL);

  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memErr) |=> (state == ST_IDLE && busErr));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && !errClear) |=> busErr);

endmodule

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CH_W   = 5,
  parameter int CNT_W  = 10,
  parameter int R_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [2:0]        cfgProt,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [2:0]        memProt,
  output logic              lastItem,
  output logic              exhaust
);

  localparam int DPROT_LO = 0;
  localparam int SPROT_LO = 3;
  localparam int R_LO     = 6;
  localparam int CNT_LO   = R_LO + R_W;
  localparam int BYTE_SH  = $clog2(DATA_W / 8);
  localparam int DESC_SH  = 4;

  logic [CH_W-1:0]   chanQ;
  logic [DATA_W-1:0] ctrlQ;
  logic [ADDR_W-1:0] srcEndQ;
  logic [ADDR_W-1:0] dstEndQ;
  logic [DATA_W-1:0] dataQ;
  logic [CNT_W-1:0]  idxQ;

  logic [CNT_W-1:0]  cnt;
  logic [R_W-1:0]    rExp;
  logic [CNT_W-1:0]  burstMask;
  logic [CNT_W-1:0]  lastIdx;
  logic [CNT_W-1:0]  back;
  logic [CNT_W-1:0]  newCnt;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] tblAddr;
  logic [DATA_W-1:0] newCtrl;

  assign cnt       = ctrlQ[CNT_LO +: CNT_W];
  assign rExp      = ctrlQ[R_LO +: R_W];
  assign exhaust   = (cnt >> rExp) == '0;
  assign burstMask = ~({CNT_W{1'b1}} << rExp);
  assign lastIdx   = exhaust ? cnt : burstMask;
  assign lastItem  = (idxQ == lastIdx);
  assign back      = cnt - idxQ;
  assign offset    = ADDR_W'(back) << BYTE_SH;
  assign tblAddr   = descBase + (ADDR_W'(chanQ) << DESC_SH);
  assign newCnt    = exhaust ? '0 : (cnt - lastIdx - CNT_W'(1));

  always_comb begin
    newCtrl                   = ctrlQ;
    newCtrl[CNT_LO +: CNT_W]  = newCnt;
  end

  always_comb begin
    memProt = cfgProt;
    case (strb.addrSel)
      AS_SRCP: memAddr = tblAddr;
      AS_DSTP: memAddr = tblAddr + ADDR_W'(4);
      AS_SRCD: begin
        memAddr = srcEndQ - offset;
        memProt = ctrlQ[SPROT_LO +: 3];
      end
      AS_DSTD: begin
        memAddr = dstEndQ - offset;
        memProt = ctrlQ[DPROT_LO +: 3];
      end
      default: memAddr = tblAddr + ADDR_W'(8);
    endcase
    memWdata = (strb.addrSel == AS_DSTD) ? dataQ : newCtrl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ   <= '0;
      ctrlQ   <= '0;
      srcEndQ <= '0;
      dstEndQ <= '0;
      dataQ   <= '0;
      idxQ    <= '0;
    end else begin
      if (strb.ldChan) chanQ   <= chanSel;
      if (strb.ldCtrl) ctrlQ   <= memRdata;
      if (strb.ldSrc)  srcEndQ <= memRdata[ADDR_W-1:0];
      if (strb.ldDst)  dstEndQ <= memRdata[ADDR_W-1:0];
      if (strb.ldData) dataQ   <= memRdata;
      if (strb.clrIdx)      idxQ <= '0;
      else if (strb.incIdx) idxQ <= idxQ + CNT_W'(1);
    end
  end

  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    strb.incIdx |-> (idxQ <= lastIdx));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CH_W   = 5,
  parameter int CNT_W  = 10,
  parameter int R_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEn,
  input  logic              start,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [2:0]        cfgProt,
  input  logic              waitOnReq,
  input  logic              chanReq,
  input  logic              errClear,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [2:0]        memProt,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [3:0]        seqState,
  output logic              done,
  output logic              busErr
);

  seqState_e stateW;
  dpStrobe_t strbW;
  logic      lastItemW;
  logic      exhaustW;

  dma_seq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .masterEn (masterEn),
    .start    (start),
    .waitOnReq(waitOnReq),
    .chanReq  (chanReq),
    .errClear (errClear),
    .memAck   (memAck),
    .memErr   (memErr),
    .lastItem (lastItemW),
    .exhaust  (exhaustW),
    .state    (stateW),
    .strb     (strbW),
    .memReq   (memReq),
    .memWe    (memWe),
    .done     (done),
    .busErr   (busErr)
  );

  dma_seq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CH_W  (CH_W),
    .CNT_W (CNT_W),
    .R_W   (R_W)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strbW),
    .chanSel (chanSel),
    .descBase(descBase),
    .cfgProt (cfgProt),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memProt (memProt),
    .lastItem(lastItemW),
    .exhaust (exhaustW)
  );

  assign seqState = stateW;

endmodule

// File: tb/dma_seq_test.sv
module dma_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;
  localparam logic [2:0] CFG_PROT = 3'b101;

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [31:0] data;
    logic [2:0]  prot;
    logic [3:0]  st;
    string       tag;
  } acc_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterEn = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  chanSel = '0;
  logic [31:0] descBase = 32'h0;
  logic [2:0]  cfgProt = CFG_PROT;
  logic        waitOnReq = 1'b0;
  logic        chanReq = 1'b0;
  logic        errClear = 1'b0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [2:0]  memProt;
  logic        memAck = 1'b0;
  logic        memErr = 1'b0;
  logic [31:0] memRdata = '0;
  logic [3:0]  seqState;
  logic        done, busErr;

  logic [31:0] mem [0:1023];
  acc_t        expQ [$];
  int          checks = 0;
  int          errors = 0;
  int          doneSeen = 0;
  int          errCountdown = -1;
  int          cyc = 0;

  dma_seq uut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .start(start),
    .chanSel(chanSel), .descBase(descBase), .cfgProt(cfgProt),
    .waitOnReq(waitOnReq), .chanReq(chanReq), .errClear(errClear),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memProt(memProt), .memAck(memAck), .memErr(memErr), .memRdata(memRdata),
    .seqState(seqState), .done(done), .busErr(busErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // memory responder and access comparison
  always @(negedge clk) begin
    if (memAck || memErr) begin
      memAck = 1'b0;
      memErr = 1'b0;
    end else if (memReq && rstN) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2/R8/R9/R10 unexpected access", memAddr, 32'hFFFF_FFFF);
        memAck = 1'b1;
      end else begin
        acc_t e;
        e = expQ.pop_front();
        chk(memAddr == e.addr, {e.tag, " address"}, memAddr, e.addr);
        chk(memWe == e.we, {e.tag, " direction"}, 32'(memWe), 32'(e.we));
        chk(seqState == e.st, {e.tag, " state code"}, 32'(seqState), 32'(e.st));
        chk(memProt == e.prot, "R5 protection", 32'(memProt), 32'(e.prot));
        if (e.we) chk(memWdata == e.data, {e.tag, " write data"}, memWdata, e.data);
        if (errCountdown == 0) begin
          memErr = 1'b1;
          expQ.delete();
        end else begin
          memAck = 1'b1;
          if (memWe) mem[memAddr[11:2]] = memWdata;
          else       memRdata = mem[memAddr[11:2]];
        end
        if (errCountdown >= 0) errCountdown--;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && done) begin
      doneSeen++;
      chk(seqState == 4'd9, "R7 state with done", 32'(seqState), 32'd9);
    end
  end

  task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d,
                      input logic [2:0] p, input logic [3:0] s, input string t);
    acc_t e;
    e.addr = a; e.we = w; e.data = d; e.prot = p; e.st = s; e.tag = t;
    expQ.push_back(e);
  endtask

  task automatic planXfer(input int ch, output int doneExp);
    logic [31:0] cw, se, de, wb, sa, da;
    int n, r, moved, base;
    base = ch * 16;
    cw = mem[(base + 8) >> 2];
    se = mem[base >> 2];
    de = mem[(base + 4) >> 2];
    n = int'(cw[19:10]);
    r = int'(cw[9:6]);
    moved = ((n + 1) <= (1 << r)) ? n + 1 : (1 << r);
    push(32'(base + 8), 1'b0, '0, CFG_PROT, 4'd1, "R3");
    push(32'(base),     1'b0, '0, CFG_PROT, 4'd2, "R3");
    push(32'(base + 4), 1'b0, '0, CFG_PROT, 4'd3, "R3");
    for (int k = 0; k < moved; k++) begin
      sa = se - 32'(4 * (n - k));
      da = de - 32'(4 * (n - k));
      push(sa, 1'b0, '0, cw[5:3], 4'd4, "R4");
      push(da, 1'b1, mem[sa[11:2]], cw[2:0], 4'd5, "R4");
    end
    wb = cw;
    wb[19:10] = (moved == n + 1) ? 10'd0 : 10'(n - moved);
    push(32'(base + 8), 1'b1, wb, CFG_PROT, 4'd7, "R6");
    doneExp = (moved == n + 1) ? 1 : 0;
  endtask

  task automatic kick(input int ch);
    @(negedge clk);
    chanSel = 5'(ch);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle(input int doneExp, input string tag);
    int t;
    t = 0;
    while (!(expQ.size() == 0 && seqState == 4'd0 && !memReq) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(expQ.size() == 0, {tag, " all accesses seen"}, 32'(expQ.size()), 32'd0);
    chk(seqState == 4'd0, {tag, " back to idle"}, 32'(seqState), 32'd0);
    chk(doneSeen == doneExp, "R7 done pulse count", 32'(doneSeen), 32'(doneExp));
  endtask

  task automatic setDesc(input int ch, input logic [31:0] se, input logic [31:0] de,
                         input int n, input int r, input logic [2:0] sp, input logic [2:0] dp);
    mem[ch * 4]     = se;
    mem[ch * 4 + 1] = de;
    mem[ch * 4 + 2] = (32'(n) << 10) | (32'(r) << 6) | (32'(sp) << 3) | 32'(dp);
  endtask

  task automatic runPass(input int ch, input string tag);
    int de;
    planXfer(ch, de);
    doneSeen = 0;
    kick(ch);
    waitIdle(de, tag);
  endtask

  initial begin
    int de;
    logic [31:0] keep;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
    setDesc(1, 32'h40C, 32'h80C, 3, 2, 3'b011, 3'b110);
    setDesc(2, 32'h524, 32'h924, 9, 2, 3'b010, 3'b001);
    setDesc(0, 32'h600, 32'hA00, 0, 0, 3'b100, 3'b001);
    setDesc(3, 32'h714, 32'hB14, 5, 3, 3'b111, 3'b000);
    setDesc(4, 32'h784, 32'hB84, 1, 1, 3'b001, 3'b010);
    setDesc(5, 32'h7C8, 32'hBC8, 2, 2, 3'b110, 3'b011);

    repeat (3) @(negedge clk);
    chk(seqState == 4'd0, "R1 reset state", 32'(seqState), 32'd0);
    chk(!memReq, "R1 reset request", 32'(memReq), 32'd0);
    chk(!done, "R1 reset done", 32'(done), 32'd0);
    chk(!busErr, "R1 reset error flag", 32'(busErr), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: disabled engine ignores start
    masterEn = 1'b0;
    kick(1);
    repeat (6) @(negedge clk);
    chk(seqState == 4'd0, "R2 start ignored", 32'(seqState), 32'd0);
    chk(!memReq, "R2 no access", 32'(memReq), 32'd0);
    masterEn = 1'b1;

    // R3..R7: burst equal to remaining count, done expected
    runPass(1, "R3");
    chk(mem[32'h800 >> 2] == mem[32'h400 >> 2], "R4 first item copied", mem[32'h800 >> 2], mem[32'h400 >> 2]);
    chk(mem[32'h80C >> 2] == mem[32'h40C >> 2], "R4 last item copied", mem[32'h80C >> 2], mem[32'h40C >> 2]);

    // R6: three chained passes of a partial transfer
    runPass(2, "R6 pass one");
    chk(mem[10][19:10] == 10'd5, "R6 count after pass one", 32'(mem[10][19:10]), 32'd5);
    runPass(2, "R6 pass two");
    runPass(2, "R6 pass three");
    chk(mem[10][19:10] == 10'd0, "R6 count after final pass", 32'(mem[10][19:10]), 32'd0);

    // R4: single item with exponent zero
    runPass(0, "R4 single");

    // R9: stall in the middle of a pass
    planXfer(3, de);
    doneSeen = 0;
    kick(3);
    repeat (9) @(negedge clk);
    masterEn = 1'b0;
    repeat (8) @(negedge clk);
    chk(seqState == 4'd8, "R9 stalled state", 32'(seqState), 32'd8);
    chk(!memReq, "R9 no access while stalled", 32'(memReq), 32'd0);
    repeat (4) @(negedge clk);
    chk(seqState == 4'd8, "R9 still stalled", 32'(seqState), 32'd8);
    masterEn = 1'b1;
    waitIdle(de, "R9");

    // R8: wait for the request to clear
    waitOnReq = 1'b1;
    chanReq = 1'b1;
    planXfer(4, de);
    doneSeen = 0;
    kick(4);
    begin
      int t;
      t = 0;
      while (seqState != 4'd6 && t < 200) begin
        @(negedge clk);
        t++;
      end
    end
    chk(seqState == 4'd6, "R8 waiting state", 32'(seqState), 32'd6);
    chk(expQ.size() == 1, "R8 only write-back pending", 32'(expQ.size()), 32'd1);
    repeat (5) @(negedge clk);
    chk(seqState == 4'd6, "R8 holds while request high", 32'(seqState), 32'd6);
    chk(!memReq, "R8 no access while waiting", 32'(memReq), 32'd0);
    chanReq = 1'b0;
    waitIdle(de, "R8");
    waitOnReq = 1'b0;

    // R10: bus error on the destination pointer read
    keep = mem[22];
    planXfer(5, de);
    doneSeen = 0;
    errCountdown = 2;
    kick(5);
    waitIdle(0, "R10");
    repeat (10) @(negedge clk);
    chk(busErr, "R10 error flag set and sticky", 32'(busErr), 32'd1);
    chk(seqState == 4'd0, "R10 idle after error", 32'(seqState), 32'd0);
    chk(mem[22] == keep, "R10 no write-back", mem[22], keep);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    @(negedge clk);
    chk(!busErr, "R10 error flag cleared", 32'(busErr), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule